// File: doc/BRIEF.md
# Galvo serial position frame receiver

This block decodes one axis of a three-wire synchronous serial link that carries galvanometer mirror positions. The three wires are a serial clock, a frame-marking sync line and a data line. A faster system clock oversamples all three wires through a synchroniser chain. The block then finds the edges of the serial clock and splits each frame into a header field, a position word and a closing parity bit.

A frame is a run of bits sent with sync high, followed by one bit sent with sync low. The sync-high run holds a 3-bit header and then a 16-bit position. The sync-low bit is parity over both the header and the position. When a frame has the correct length, the block gives a one-cycle `frame_valid` pulse and presents the position, the header and a parity verdict. A frame of the wrong length produces a one-cycle `frame_error` pulse instead. One instance serves one axis, so a multi-axis link uses one instance per data line. All instances share the clock and sync wires.

Top module: `galvo_rx`

## Requirements
- R1: While `rst_n` is low and right after it is released, `frame_valid` and `frame_error` are 0, and `position`, `header` and `parity_ok` are all zero.
- R2: The sync level of a bit is taken at the rising edge of `ser_clk`, and the data value at the following falling edge. Changes of `ser_data` or `ser_sync` during the high phase of `ser_clk` do not alter the decoded frame, provided both are back at the wanted level before the falling edge and before the next rising edge respectively.
- R3: The first 3 sync-high bits of a frame form `header`. The first of them lands in `header[2]` and the third in `header[0]`.
- R4: The sync-high bits after the header form `position`. The first of them lands in `position[15]`, and the last one before the sync-low bit lands in `position[0]`.
- R5: `frame_valid` rises only after a sync-low bit. With it, `parity_ok` is 1 exactly when the XOR of the 3 header bits and the 16 position bits equals the value of the sync-low bit. A parity mismatch still gives `frame_valid`, with `parity_ok` = 0.
- R6: `frame_valid` is high for exactly one system clock per good frame. `position`, `header` and `parity_ok` change only in the cycle where `frame_valid` is high, and they hold their values until the next good frame.
- R7: If the sync-low bit arrives after fewer than 19 sync-high bits (fewer than 16 position bits), the block pulses `frame_error` for one cycle. It gives no `frame_valid`, and `position`, `header` and `parity_ok` keep their previous values.
- R8: When a 20th consecutive sync-high bit arrives, the block pulses `frame_error` once. It ignores the remaining sync-high bits and the sync-low bit that ends the run, with no `frame_valid`, and decodes the following frame normally.
- R9: The header and position accumulators are cleared by every sync-low bit, so frames sent back to back decode independently of one another.
- R10: `frame_valid` and `frame_error` are never high together. With default parameters, the result of a frame appears at the ports no more than 4 system clocks after the falling `ser_clk` edge of its sync-low bit. This requires `ser_clk` to run at no more than a quarter of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_sync | input | 1 | Frame marker: high for header and position bits, low for the parity bit |
| ser_data | input | 1 | Serial data line of this axis |
| frame_valid | output | 1 | One-cycle strobe: a frame of correct length has been received |
| frame_error | output | 1 | One-cycle strobe: a frame of wrong length has been detected |
| position | output | 16 | Position word of the last good frame |
| header | output | 3 | Header field of the last good frame |
| parity_ok | output | 1 | Parity verdict of the last good frame |

## Verification
A miscounted or stale bit counter shows up at the ports as a wrong kind of strobe. Examples are a `frame_error` where a good frame was expected, or a `frame_valid` after a short or long run. Either shows up within four system clocks of the sync-low bit, or at the 20th sync-high bit. Shift or ordering faults show as a position or header with swapped or shifted bits at the next `frame_valid`. An accumulator that was not cleared corrupts the position or parity of the frame that follows. The scoreboard also compares the held outputs at every error strobe and after idle gaps, so a register that updates outside a good frame is caught at the next event.

// File: rtl/galvo_rx_pkg.sv
package galvo_rx_pkg;

   // One decoded serial bit: strobe marks the falling serial clock edge,
   // sync_lvl is the sync level captured at the preceding rising edge,
   // value is the data level at the falling edge.
   typedef struct packed {
      logic strobe;
      logic sync_lvl;
      logic value;
   } serial_bit_t;

endpackage

// File: rtl/galvo_rx_sync.sv
module galvo_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end

         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/galvo_rx_bitsamp.sv
module galvo_rx_bitsamp
   import galvo_rx_pkg::*;
#(
   parameter bit EVT_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk_s,
   input  logic        sync_s,
   input  logic        data_s,
   output serial_bit_t bit_o
);

   logic        sclk_d;
   logic        sync_cap;
   logic        armed;
   logic        rise;
   logic        fall;
   serial_bit_t evt_c;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         sync_cap <= 1'b0;
         armed    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (rise) begin
            sync_cap <= sync_s;
            armed    <= 1'b1;
         end else if (fall) begin
            armed <= 1'b0;
         end
      end
   end

   always_comb begin
      evt_c.strobe   = fall & armed;
      evt_c.sync_lvl = sync_cap;
      evt_c.value    = data_s;
   end

   generate
      if (EVT_REG) begin : g_reg
         serial_bit_t bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= '0;
            else        bit_q <= evt_c;
         end
         assign bit_o = bit_q;
      end else begin : g_comb
         assign bit_o = evt_c;
      end
   endgenerate

endmodule

// File: rtl/galvo_rx_asm.sv
module galvo_rx_asm
   import galvo_rx_pkg::*;
#(
   parameter int HDR_BITS  = 3,
   parameter int DATA_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  serial_bit_t          bit_i,
   output logic                 frame_valid,
   output logic                 frame_error,
   output logic [DATA_BITS-1:0] position,
   output logic [HDR_BITS-1:0]  header,
   output logic                 parity_ok
);

   localparam int HIGH_BITS = HDR_BITS + DATA_BITS;
   localparam int CNT_W     = $clog2(HIGH_BITS + 1);
   localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(HIGH_BITS);

   logic [CNT_W-1:0]     cnt_q;
   logic [HDR_BITS-1:0]  hdr_acc;
   logic [DATA_BITS-1:0] dat_acc;
   logic                 par_acc;
   logic                 discard_q;
   logic                 valid_q;
   logic                 err_q;
   logic [DATA_BITS-1:0] pos_q;
   logic [HDR_BITS-1:0]  hdr_q;
   logic                 pok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         hdr_acc   <= '0;
         dat_acc   <= '0;
         par_acc   <= 1'b0;
         discard_q <= 1'b0;
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
         pos_q     <= '0;
         hdr_q     <= '0;
         pok_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         if (bit_i.strobe) begin
            if (bit_i.sync_lvl) begin
               if (!discard_q) begin
                  if (cnt_q == FULL_C) begin
                     // run too long: flag once, drop until sync falls
                     err_q     <= 1'b1;
                     discard_q <= 1'b1;
                     cnt_q     <= '0;
                     hdr_acc   <= '0;
                     dat_acc   <= '0;
                     par_acc   <= 1'b0;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     par_acc <= par_acc ^ bit_i.value;
                     if (cnt_q < HDR_C)
                        hdr_acc <= HDR_BITS'({hdr_acc, bit_i.value});
                     else
                        dat_acc <= DATA_BITS'({dat_acc, bit_i.value});
                  end
               end
            end else begin
               if (!discard_q) begin
                  if (cnt_q == FULL_C) begin
                     valid_q <= 1'b1;
                     pos_q   <= dat_acc;
                     hdr_q   <= hdr_acc;
                     pok_q   <= (par_acc == bit_i.value);
                  end else begin
                     err_q <= 1'b1;
                  end
               end
               discard_q <= 1'b0;
               cnt_q     <= '0;
               hdr_acc   <= '0;
               dat_acc   <= '0;
               par_acc   <= 1'b0;
            end
         end
      end
   end

   assign frame_valid = valid_q;
   assign frame_error = err_q;
   assign position    = pos_q;
   assign header      = hdr_q;
   assign parity_ok   = pok_q;

endmodule

// File: rtl/galvo_rx.sv
module galvo_rx
   import galvo_rx_pkg::*;
#(
   parameter int HDR_BITS    = 3,
   parameter int DATA_BITS   = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit EVT_REG     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_sync,
   input  logic                 ser_data,
   output logic                 frame_valid,
   output logic                 frame_error,
   output logic [DATA_BITS-1:0] position,
   output logic [HDR_BITS-1:0]  header,
   output logic                 parity_ok
);

   localparam int LINES = 3;

   generate
      if (HDR_BITS < 1)   begin : g_bad_hdr  $error("HDR_BITS must be at least 1");   end
      if (DATA_BITS < 1)  begin : g_bad_data $error("DATA_BITS must be at least 1");  end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic [LINES-1:0] raw_lines;
   logic [LINES-1:0] syn_lines;
   serial_bit_t      bit_evt;
   logic             bit_strobe;
   logic             bit_sync;

   assign raw_lines = {ser_clk, ser_sync, ser_data};

   galvo_rx_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (syn_lines)
   );

   galvo_rx_bitsamp #(
      .EVT_REG (EVT_REG)
   ) u_bitsamp (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (syn_lines[2]),
      .sync_s (syn_lines[1]),
      .data_s (syn_lines[0]),
      .bit_o  (bit_evt)
   );

   assign bit_strobe = bit_evt.strobe;
   assign bit_sync   = bit_evt.sync_lvl;

   galvo_rx_asm #(
      .HDR_BITS  (HDR_BITS),
      .DATA_BITS (DATA_BITS)
   ) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_i       (bit_evt),
      .frame_valid (frame_valid),
      .frame_error (frame_error),
      .position    (position),
      .header      (header),
      .parity_ok   (parity_ok)
   );

endmodule

// File: rtl/galvo_rx_chk.sv
module galvo_rx_chk #(
   parameter int HDR_BITS  = 3,
   parameter int DATA_BITS = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_valid,
   input logic                 frame_error,
   input logic [DATA_BITS-1:0] position,
   input logic [HDR_BITS-1:0]  header,
   input logic                 parity_ok,
   input logic                 bit_strobe,
   input logic                 bit_sync
);

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   assert_outputs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> ($stable(position) && $stable(header) && $stable(parity_ok)));

   assert_error_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_error |=> !frame_error);

   assert_valid_after_low_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(bit_strobe && !bit_sync));

   assert_no_double_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && frame_error));

endmodule

bind galvo_rx galvo_rx_chk #(
   .HDR_BITS  (HDR_BITS),
   .DATA_BITS (DATA_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .frame_error (frame_error),
   .position    (position),
   .header      (header),
   .parity_ok   (parity_ok),
   .bit_strobe  (bit_strobe),
   .bit_sync    (bit_sync)
);

// File: tb/galvo_rx_tb.sv
module galvo_rx_tb;

   localparam int HALF     = 4;
   localparam int WATCHDOG = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_sync = 1'b0;
   logic        ser_data = 1'b0;
   logic        frame_valid;
   logic        frame_error;
   logic [15:0] position;
   logic [2:0]  header;
   logic        parity_ok;

   always #4 clk = ~clk;

   galvo_rx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk     (ser_clk),
      .ser_sync    (ser_sync),
      .ser_data    (ser_data),
      .frame_valid (frame_valid),
      .frame_error (frame_error),
      .position    (position),
      .header      (header),
      .parity_ok   (parity_ok)
   );

   typedef struct {
      bit          is_err;
      logic [15:0] pos;
      logic [2:0]  hdr;
      logic        pok;
   } exp_t;

   exp_t        sb_q[$];
   int          n_checks = 0;
   int          n_fails  = 0;
   logic [15:0] last_pos = '0;
   logic [2:0]  last_hdr = '0;
   logic        last_pok = 1'b0;
   bit          done = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
      end
   endtask

   // Monitor: pops the scoreboard whenever the design reports a frame.
   always @(negedge clk) begin
      if (rst_n && !done && (frame_valid || frame_error)) begin
         if (sb_q.size() == 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7 unexpected strobe: actual valid=%0b error=%0b expected none",
                     frame_valid, frame_error);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.is_err) begin
               check("R7", "frame_error strobe", {31'd0, frame_error}, 32'd1);
               check("R7", "no frame_valid",     {31'd0, frame_valid}, 32'd0);
               check("R7", "position held",      {16'd0, position},    {16'd0, last_pos});
               check("R7", "header held",        {29'd0, header},      {29'd0, last_hdr});
            end else begin
               check("R6",  "frame_valid strobe", {31'd0, frame_valid}, 32'd1);
               check("R10", "no frame_error",     {31'd0, frame_error}, 32'd0);
               check("R4",  "position",           {16'd0, position},    {16'd0, e.pos});
               check("R3",  "header",             {29'd0, header},      {29'd0, e.hdr});
               check("R5",  "parity_ok",          {31'd0, parity_ok},   {31'd0, e.pok});
               last_pos = e.pos;
               last_hdr = e.hdr;
               last_pok = e.pok;
            end
         end
      end
   end

   // One serial bit; with glitch set, data is wrong until just after the
   // rising edge and sync toggles during the high phase (R2).
   task automatic send_bit(input logic s, input logic d, input bit glitch);
      @(negedge clk);
      ser_sync = s;
      ser_data = glitch ? ~d : d;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      if (glitch) begin
         @(negedge clk);
         ser_data = d;
         ser_sync = ~s;
         repeat (HALF - 2) @(negedge clk);
         ser_sync = s;
         @(negedge clk);
      end else begin
         repeat (HALF) @(negedge clk);
      end
      ser_clk = 1'b0;
   endtask

   // Driver: pushes the expected result, then sends nhigh sync-high bits
   // and one sync-low parity bit.
   task automatic send_frame(input logic [18:0] hd, input int nhigh,
                             input logic par, input bit glitch);
      exp_t e;
      e.is_err = (nhigh != 19);
      e.pos    = hd[15:0];
      e.hdr    = hd[18:16];
      e.pok    = ((^hd) == par);
      sb_q.push_back(e);
      for (int i = 0; i < nhigh; i++) begin
         logic b;
         b = (i < 19) ? hd[18-i] : logic'(i % 2);
         send_bit(1'b1, b, glitch);
      end
      send_bit(1'b0, par, 1'b0);
      repeat (4) @(negedge clk);
      #1;
      check("R10", "result within 4 clocks (pending items)", sb_q.size(), 32'd0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check("R1", "frame_valid in reset", {31'd0, frame_valid}, 32'd0);
      check("R1", "position in reset",    {16'd0, position},    32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "frame_error after reset", {31'd0, frame_error}, 32'd0);
      check("R1", "header after reset",      {29'd0, header},      32'd0);
      check("R1", "parity_ok after reset",   {31'd0, parity_ok},   32'd0);

      // R3 R4 R5: good frame, correct parity
      send_frame({3'b101, 16'hA5C3}, 19, ^{3'b101, 16'hA5C3}, 1'b0);
      // R5: wrong parity still valid, parity_ok low; R9 back to back
      send_frame({3'b011, 16'h3C5A}, 19, ~(^{3'b011, 16'h3C5A}), 1'b0);
      // R4: single LSB set lands in bit 0
      send_frame({3'b010, 16'h0001}, 19, ^{3'b010, 16'h0001}, 1'b0);
      // R2: late data and sync glitch during high phase
      send_frame({3'b110, 16'h8000}, 19, ^{3'b110, 16'h8000}, 1'b1);

      // R6: outputs hold across an idle gap
      repeat (40) @(negedge clk);
      check("R6", "position held in idle",  {16'd0, position},  32'h8000);
      check("R6", "header held in idle",    {29'd0, header},    32'd6);
      check("R6", "parity_ok held in idle", {31'd0, parity_ok}, 32'd1);

      // R7: short frames
      send_frame({3'b111, 16'h1234}, 10, 1'b0, 1'b0);
      send_frame({3'b111, 16'h1234}, 2,  1'b1, 1'b0);
      // R8: sync-high run too long, then recovery
      send_frame({3'b001, 16'hBEEF}, 23, 1'b1, 1'b0);
      send_frame({3'b111, 16'hFFFF}, 19, ^{3'b111, 16'hFFFF}, 1'b0);
      // R9: all-zero frame with parity set -> parity_ok low
      send_frame({3'b000, 16'h0000}, 19, 1'b1, 1'b0);
      // R2 R5: glitch frame right after, correct parity
      send_frame({3'b100, 16'h7E81}, 19, ^{3'b100, 16'h7E81}, 1'b1);

      repeat (20) @(negedge clk);
      check("R6", "final position held", {16'd0, position}, 32'h7E81);
      check("R9", "scoreboard drained", sb_q.size(), 32'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule